// File: doc/BRIEF.md
# External Clock Supervisor with Internal Fallback

This block decides which oscillator drives the system clock. After reset the system runs from the internal oscillator. Software turns on the external oscillator, waits until the block reports it stable and then asks for the switch. The block also raises a start-up timeout flag, so software never has to wait forever for a crystal that does not start. The source change goes through a break-before-make clock multiplexer, so the output clock has no runt pulses.

While the external clock drives the system, an optional supervisor watches it from the internal clock domain. If the external clock stops producing edges, the block records a sticky failure and returns the system to the internal oscillator divided by eight. It also drops the oscillator enable and the switch request, and can raise an interrupt. The external source stays locked out until software clears the failure flag.

All control and status go through a small register port in the internal clock domain. Register 0 is control: bit 0 oscillator enable, bit 1 switch request, bit 2 supervision enable, bit 3 interrupt enable. Register 1 is status: bit 0 stable, bit 1 start-up timeout, bit 2 failure (write 1 to clear), bits 5:4 active source.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset, control and status read 0, the oscillator enable output is 0, and `sys_clk` runs at the `clk_int` rate.
- R2: The `osc_enable` output follows control bit 0.
- R3: Status bit 0 (stable) rises only after STABLE_EDGES rising edges of `clk_ext` have been counted since the oscillator was enabled. It is 0 while the oscillator enable is 0.
- R4: Status bit 1 (timeout) sets after the oscillator has been enabled for START_TIMEOUT `clk_int` cycles without becoming stable. It clears when the oscillator enable is cleared, and it is never 1 while the enable is 0.
- R5: The external clock is selected only while the switch request is set and the clock is stable. In every other case without a failure, the undivided internal clock is selected.
- R6: At most one multiplexer leg is enabled at any time. Status bits 5:4 report the active source: 0 internal, 1 external, 2 internal divided by 8, 3 in transition.
- R7: With supervision enabled and the external source selected, MISS_LIMIT consecutive `clk_int` cycles without observed external activity set the failure flag. A running external clock never sets it, and with supervision disabled the flag is never set.
- R8: On a failure the system clock moves to `clk_int` divided by 8 and the active source reads 2. Control bits 0 and 1 are cleared by hardware.
- R9: `irq` is high exactly when the failure flag and control bit 3 are both set.
- R10: The failure flag is sticky. Writing 0 to status bit 2 has no effect and writing 1 clears it. While it is set, the external source cannot be selected.
- R11: Control bits 3:0 read back as written unless hardware cleared them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock, reference and register clock |
| clk_ext | input | 1 | External oscillator clock under supervision |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sys_clk | output | 1 | Glitch-free system clock |
| osc_enable | output | 1 | Enable to the external oscillator |
| irq | output | 1 | Clock failure interrupt |

## Verification
The bench builds the block with STABLE_EDGES=64, START_TIMEOUT=200, MISS_LIMIT=16, an external activity divider of 4 and a fallback divide of 8. With these values, the stable count, the start-up timeout and the miss window are each reached within a few hundred internal cycles. This lets one run cover start-up failure, a clean switch, a clock loss with fallback and lockout, and recovery. The external clock runs faster than the internal one (6 ns against 10 ns), and the bench can stop it at will. That exercises both the domain crossings and the multiplexer's path out of a dead source.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_DIV = 2'd2
    } src_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int CB_OSC   = 0;
    localparam int CB_USE   = 1;
    localparam int CB_WATCH = 2;
    localparam int CB_IRQ   = 3;

    localparam int SB_STABLE = 0;
    localparam int SB_TMO    = 1;
    localparam int SB_FAIL   = 2;
    localparam int SB_ACT    = 4;

endpackage

// File: rtl/clkmon_ext_side.sv
// External clock domain: start-up edge counter and a slow activity beat.
// Held in reset (asynchronously) whenever the oscillator enable is low;
// the release is synchronised to clk_ext.
module clkmon_ext_side #(
    parameter int STABLE_EDGES = 2048,
    parameter int EXT_DIV_LOG2 = 2
) (
    input  logic clk_ext,
    input  logic clr_n,
    output logic ready,
    output logic beat
);
    localparam int CW = $clog2(STABLE_EDGES + 1);

    typedef struct packed {
        logic                  rel1;
        logic                  rel2;
        logic [CW-1:0]         cnt;
        logic                  ready;
        logic [EXT_DIV_LOG2:0] div;
    } ext_state_t;

    ext_state_t q, d;

    always_comb begin
        d      = q;
        d.rel1 = 1'b1;
        d.rel2 = q.rel1;
        if (q.rel2) begin
            d.div = q.div + 1'b1;
            if (!q.ready) begin
                if (q.cnt == CW'(STABLE_EDGES - 1)) begin
                    d.ready = 1'b1;
                end
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ext or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready = q.ready;
    assign beat  = q.div[EXT_DIV_LOG2];

endmodule

// File: rtl/clkmon_miss_det.sv
// Internal-domain detector: synchronises the external beat and counts
// reference cycles without a beat change.
module clkmon_miss_det #(
    parameter int MISS_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_async,
    input  logic arm,
    output logic fail_hit
);
    localparam int MW = $clog2(MISS_LIMIT + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [MW-1:0] cnt;
    } miss_state_t;

    miss_state_t q, d;
    logic        seen;

    always_comb begin
        seen     = q.s2 ^ q.s3;
        d        = q;
        d.s1     = beat_async;
        d.s2     = q.s1;
        d.s3     = q.s2;
        fail_hit = 1'b0;
        if (!arm || seen) begin
            d.cnt = '0;
        end else begin
            if (q.cnt == MW'(MISS_LIMIT - 1)) begin
                fail_hit = 1'b1;
            end
            if (q.cnt != MW'(MISS_LIMIT)) begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/clkmon_clk_switch.sv
// Break-before-make clock multiplexer. Each leg owns a two-stage enable
// clocked on the falling edge of its own source; a leg may only turn on
// once every other leg is off. kill clears a leg even if its clock is dead.
module clkmon_clk_switch #(
    parameter int NSRC     = 3,
    parameter int INIT_SRC = 0
) (
    input  logic [NSRC-1:0] src_clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] kill,
    output logic [NSRC-1:0] leg_en,
    output logic            clk_out
);
    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        localparam logic INIT = (i == INIT_SRC);
        logic others;
        logic leg_clr_n;
        logic s1_q, s1_d;
        logic en_q;

        assign others    = |(leg_en & ~(NSRC'(1) << i));
        assign leg_clr_n = rst_n & ~kill[i];
        assign s1_d      = req[i] & ~others;

        always_ff @(negedge src_clk[i] or negedge leg_clr_n) begin
            if (!leg_clr_n) begin
                s1_q <= INIT;
                en_q <= INIT;
            end else begin
                s1_q <= s1_d;
                en_q <= s1_q;
            end
        end

        assign leg_en[i] = en_q;
    end

    assign clk_out = |(src_clk & leg_en);

endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
    import clkmon_pkg::*;
#(
    parameter int STABLE_EDGES      = 2048,
    parameter int START_TIMEOUT     = 65536,
    parameter int MISS_LIMIT        = 32,
    parameter int EXT_DIV_LOG2      = 2,
    parameter int FALLBACK_DIV_LOG2 = 3
) (
    input  logic              clk_int,
    input  logic              clk_ext,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_clk,
    output logic              osc_enable,
    output logic              irq
);
    localparam int TW = $clog2(START_TIMEOUT + 1);

    typedef struct packed {
        logic                         osc_en;
        logic                         use_ext;
        logic                         watch_en;
        logic                         irq_en;
        src_e                         sel;
        logic                         fail;
        logic                         timeout;
        logic [TW-1:0]                tmo_cnt;
        logic                         rdy_s1;
        logic                         rdy_s2;
        logic [NUM_SRC-1:0]           en_s1;
        logic [NUM_SRC-1:0]           en_s2;
        logic [FALLBACK_DIV_LOG2-1:0] div;
    } state_t;

    state_t q, d;

    logic               ext_clr_n;
    logic               ext_ready;
    logic               ext_beat;
    logic               arm;
    logic               fail_hit;
    logic               stable;
    logic               clk_div;
    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] kill;
    logic [NUM_SRC-1:0] leg_en;
    logic [1:0]         act_code;
    logic               wr_ctrl;
    logic               wr_stat;
    logic               unused_wdata;

    // observation points for the bound checker
    logic               fail_flag;
    logic               timeout_flag;
    logic               osc_on;
    logic               watch_on;
    src_e               sel_now;

    assign unused_wdata = ^reg_wdata[DATA_W-1:4];

    clkmon_ext_side #(
        .STABLE_EDGES (STABLE_EDGES),
        .EXT_DIV_LOG2 (EXT_DIV_LOG2)
    ) u_ext (
        .clk_ext (clk_ext),
        .clr_n   (ext_clr_n),
        .ready   (ext_ready),
        .beat    (ext_beat)
    );

    clkmon_miss_det #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_miss (
        .clk        (clk_int),
        .rst_n      (rst_n),
        .beat_async (ext_beat),
        .arm        (arm),
        .fail_hit   (fail_hit)
    );

    clkmon_clk_switch #(
        .NSRC     (NUM_SRC),
        .INIT_SRC (int'(SRC_INT))
    ) u_mux (
        .src_clk (src_clk),
        .rst_n   (rst_n),
        .req     (req),
        .kill    (kill),
        .leg_en  (leg_en),
        .clk_out (sys_clk)
    );

    always_comb begin
        stable  = q.rdy_s2 & q.osc_en;
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADDR_STAT);

        d        = q;
        d.div    = q.div + 1'b1;
        d.rdy_s1 = ext_ready;
        d.rdy_s2 = q.rdy_s1;
        d.en_s1  = leg_en;
        d.en_s2  = q.en_s1;

        if (wr_ctrl) begin
            d.osc_en   = reg_wdata[CB_OSC];
            d.use_ext  = reg_wdata[CB_USE];
            d.watch_en = reg_wdata[CB_WATCH];
            d.irq_en   = reg_wdata[CB_IRQ];
        end
        if (wr_stat && reg_wdata[SB_FAIL]) begin
            d.fail = 1'b0;
        end
        // a detected loss wins over a same-cycle software access
        if (fail_hit) begin
            d.fail    = 1'b1;
            d.osc_en  = 1'b0;
            d.use_ext = 1'b0;
        end

        // start-up timeout
        if (!d.osc_en) begin
            d.tmo_cnt = '0;
            d.timeout = 1'b0;
        end else if (q.osc_en && !stable && !q.timeout) begin
            if (q.tmo_cnt == TW'(START_TIMEOUT - 1)) begin
                d.timeout = 1'b1;
            end
            d.tmo_cnt = q.tmo_cnt + 1'b1;
        end

        // source selection
        if (q.fail || fail_hit) begin
            d.sel = SRC_DIV;
        end else if (q.use_ext && stable) begin
            d.sel = SRC_EXT;
        end else begin
            d.sel = SRC_INT;
        end
    end

    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req           = NUM_SRC'(1) << q.sel;
        kill          = '0;
        kill[SRC_EXT] = q.fail;
        case (q.en_s2)
            3'b001:  act_code = 2'd0;
            3'b010:  act_code = 2'd1;
            3'b100:  act_code = 2'd2;
            default: act_code = 2'd3;
        endcase
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CB_OSC]   = q.osc_en;
            reg_rdata[CB_USE]   = q.use_ext;
            reg_rdata[CB_WATCH] = q.watch_en;
            reg_rdata[CB_IRQ]   = q.irq_en;
        end else begin
            reg_rdata[SB_STABLE]       = stable;
            reg_rdata[SB_TMO]          = q.timeout;
            reg_rdata[SB_FAIL]         = q.fail;
            reg_rdata[SB_ACT+1:SB_ACT] = act_code;
        end
    end

    assign clk_div      = q.div[FALLBACK_DIV_LOG2-1];
    assign src_clk      = {clk_div, clk_ext, clk_int};
    assign ext_clr_n    = rst_n & q.osc_en;
    assign arm          = q.watch_en && (q.sel == SRC_EXT);
    assign osc_enable   = q.osc_en;
    assign irq          = q.fail & q.irq_en;

    assign fail_flag    = q.fail;
    assign timeout_flag = q.timeout;
    assign osc_on       = q.osc_en;
    assign watch_on     = q.watch_en;
    assign sel_now      = q.sel;

endmodule

// File: rtl/clk_fail_guard_chk.sv
module clk_fail_guard_chk
    import clkmon_pkg::*;
(
    input logic         clk_int,
    input logic         rst_n,
    input logic         irq,
    input logic         fail_flag,
    input logic         timeout_flag,
    input logic         osc_on,
    input logic         watch_on,
    input logic         stable,
    input src_e         sel_now,
    input logic [2:0]   leg_en
);
    // R4
    tmo_needs_osc_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        timeout_flag |-> osc_on);

    // R5
    ext_needs_stable_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        (sel_now == SRC_EXT) |-> $past(stable));

    // R6
    single_leg_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $onehot0(leg_en));

    // R7
    fail_needs_watch_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(fail_flag) |-> $past(watch_on));

    // R8
    fail_drops_osc_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        $rose(fail_flag) |-> !osc_on);

    // R9
    irq_needs_fail_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        irq |-> fail_flag);

    // R10
    ext_locked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
        fail_flag |-> (sel_now != SRC_EXT));

endmodule

bind clk_fail_guard clk_fail_guard_chk u_chk (
    .clk_int      (clk_int),
    .rst_n        (rst_n),
    .irq          (irq),
    .fail_flag    (fail_flag),
    .timeout_flag (timeout_flag),
    .osc_on       (osc_on),
    .watch_on     (watch_on),
    .stable       (stable),
    .sel_now      (sel_now),
    .leg_en       (leg_en)
);

// File: tb/clk_fail_guard_test.sv
module clk_fail_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int EXT_HALF   = 3;

    logic       clk_int = 1'b0;
    logic       clk_ext = 1'b0;
    logic       ext_run = 1'b1;
    logic       rst_n   = 1'b0;
    logic       reg_wr  = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_clk;
    logic       osc_enable;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    int sys_edges = 0;
    bit finished = 1'b0;

    clk_fail_guard #(
        .STABLE_EDGES      (64),
        .START_TIMEOUT     (200),
        .MISS_LIMIT        (16),
        .EXT_DIV_LOG2      (2),
        .FALLBACK_DIV_LOG2 (3)
    ) uut (
        .clk_int    (clk_int),
        .clk_ext    (clk_ext),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sys_clk    (sys_clk),
        .osc_enable (osc_enable),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk_int = ~clk_int;

    always begin
        #(EXT_HALF);
        if (ext_run) clk_ext = ~clk_ext;
    end

    always @(posedge sys_clk) sys_edges <= sys_edges + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_int);
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk_int);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk_int);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk_int);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic sys_rate(output int n);
        int start;
        @(negedge clk_int);
        start = sys_edges;
        cycles(100);
        n = sys_edges - start;
    endtask

    // status fields: bit0 stable, bit1 timeout, bit2 fail, bits5:4 active
    logic [7:0] ctrl_v;
    logic [7:0] st_v;
    int         rate;

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(3);

        // R1 reset state
        rd(1'b0, ctrl_v);
        chk("R1 ctrl after reset", int'(ctrl_v), 0);
        rd(1'b1, st_v);
        chk("R1 status after reset", int'(st_v), 0);
        chk("R1 osc_enable after reset", int'(osc_enable), 0);
        sys_rate(rate);
        chk_rng("R1 sys_clk rate on internal", rate, 99, 101);

        // R5 switch request without oscillator
        wr(1'b0, 8'h02);
        cycles(80);
        rd(1'b0, ctrl_v);
        chk("R11 ctrl readback", int'(ctrl_v), 2);
        rd(1'b1, st_v);
        chk("R5 stays internal without stable", int'(st_v[5:4]), 0);
        chk("R3 not stable while oscillator off", int'(st_v[0]), 0);

        // R4 start-up timeout with a dead oscillator
        ext_run = 1'b0;
        wr(1'b0, 8'h03);
        chk("R2 osc_enable follows ctrl", int'(osc_enable), 1);
        cycles(148);
        rd(1'b1, st_v);
        chk("R4 no timeout early", int'(st_v[1]), 0);
        chk("R3 not stable without edges", int'(st_v[0]), 0);
        cycles(70);
        rd(1'b1, st_v);
        chk("R4 timeout set", int'(st_v[1]), 1);
        chk("R5 still internal after timeout", int'(st_v[5:4]), 0);
        wr(1'b0, 8'h02);
        cycles(2);
        rd(1'b1, st_v);
        chk("R4 timeout cleared with enable", int'(st_v[1]), 0);
        chk("R2 osc_enable low", int'(osc_enable), 0);

        // R3 stable count
        ext_run = 1'b1;
        wr(1'b0, 8'h01);
        cycles(28);
        rd(1'b1, st_v);
        chk("R3 not stable before count", int'(st_v[0]), 0);
        cycles(40);
        rd(1'b1, st_v);
        chk("R3 stable after count", int'(st_v[0]), 1);
        chk("R5 no switch without request", int'(st_v[5:4]), 0);
        chk("R4 no timeout when stable", int'(st_v[1]), 0);

        // R5 switch to external
        wr(1'b0, 8'h03);
        cycles(20);
        rd(1'b1, st_v);
        chk("R6 active reads external", int'(st_v[5:4]), 1);
        sys_rate(rate);
        chk_rng("R5 sys_clk rate on external", rate, 160, 172);

        // R7 supervision without false alarm
        wr(1'b0, 8'h0F);
        cycles(300);
        rd(1'b1, st_v);
        chk("R7 no failure on live clock", int'(st_v[2]), 0);
        chk("R9 irq low without failure", int'(irq), 0);

        // R7/R8 clock loss
        ext_run = 1'b0;
        cycles(60);
        rd(1'b1, st_v);
        chk("R7 failure detected", int'(st_v[2]), 1);
        chk("R9 irq raised", int'(irq), 1);
        chk("R8 active reads divided internal", int'(st_v[5:4]), 2);
        rd(1'b0, ctrl_v);
        chk("R8 hardware cleared enable and request", int'(ctrl_v), 8'h0C);
        chk("R8 osc_enable dropped", int'(osc_enable), 0);
        sys_rate(rate);
        chk_rng("R8 sys_clk rate divided by 8", rate, 11, 14);

        // R9 interrupt masked
        wr(1'b0, 8'h04);
        cycles(2);
        chk("R9 irq follows enable", int'(irq), 0);

        // R10 writing 0 does not clear
        wr(1'b1, 8'h00);
        cycles(2);
        rd(1'b1, st_v);
        chk("R10 flag survives zero write", int'(st_v[2]), 1);

        // R10 lockout while flag set
        ext_run = 1'b1;
        wr(1'b0, 8'h07);
        cycles(100);
        rd(1'b1, st_v);
        chk("R3 stable again after restart", int'(st_v[0]), 1);
        chk("R10 external locked out", int'(st_v[5:4]), 2);

        wr(1'b1, 8'h04);
        cycles(60);
        rd(1'b1, st_v);
        chk("R10 flag cleared by write 1", int'(st_v[2]), 0);
        chk("R10 external selected after clear", int'(st_v[5:4]), 1);

        // R7 supervision disabled
        wr(1'b0, 8'h03);
        ext_run = 1'b0;
        cycles(100);
        rd(1'b1, st_v);
        chk("R7 no failure when supervision off", int'(st_v[2]), 0);
        chk("R7 external stays selected", int'(st_v[5:4]), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule